// File: doc/BRIEF.md
# Packet-Synchronized DMA Transfer Sequencer

This block sequences one DMA channel in which every hardware request from a buffered peripheral moves a fixed packet of elements rather than a whole frame. Software programs the channel shape: elements per frame, frames per block, element width, packet length and burst length. It also programs the two sync-mode bits, which side of the transfer is the peripheral, and the two base addresses. A start pulse then arms the channel. The sequencer turns each request into one or more access commands. Each command carries a read address, a write address and a beat count, and is offered on a valid/ready handshake to the memory side.

The full block is always moved, whatever the packet length. A packet never shares a burst with its neighbour: a burst that would run past the packet edge is cut short. When the packet length does not divide the block, the last request moves only what is left. The peripheral side keeps one fixed address, and the memory side advances by the bytes of each accepted command. One request arriving during a packet is held and serviced next. A further request is reported as an overflow. A one-cycle end-of-packet pulse marks each finished packet, and an end-of-block pulse accompanies the last one. After that the channel goes idle until it is started again.

Top module: `pkt_xfer_seq`

## Requirements
- R1: A start with a zero element count, zero frame count, zero packet length, burst length of 0 or above MAX_BURST, element size code 3, or either sync bit clear raises cfg_err for one cycle (the cycle after start), issues no command and leaves busy low.
- R2: Across one block the accepted beat counts sum to elements-per-frame × frames-per-block, and end-of-block follows the command that completes that sum.
- R3: Each serviced request moves exactly min(packet length, elements left in block) beats before end-of-packet.
- R4: Every command carries min(burst length, elements left in the current packet) beats, so no command crosses a packet boundary.
- R5: When the packet length does not divide the block, the last packet carries the remainder only.
- R6: Element size code 0/1/2 means 1/2/4 bytes. With cfg_pkt_on_dst = 0 the read address stays at the source base and the write address advances by beats << size after each accepted command; with 1 the write address stays at the destination base and the read address advances.
- R7: While cmd_valid is high and cmd_ready low, cmd_valid and every command field hold their values into the next cycle.
- R8: pkt_done pulses for one cycle, in the cycle after the last command of a packet is accepted; blk_done pulses in that same cycle for the final packet only.
- R9: A request arriving while a packet is in progress is held and starts the next packet without a further request; a request arriving while one is already held raises ovf_err for one cycle.
- R10: After end-of-block the channel is idle (busy low) and requests issue no command until the next start.
- R11: After a valid start and before any request, busy is high and no command is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm pulse; configuration is captured when idle |
| cfg_frame_elems | input | CNT_W | Elements per frame |
| cfg_block_frames | input | CNT_W | Frames per block |
| cfg_elem_size | input | 2 | Element size code: 0=1 B, 1=2 B, 2=4 B |
| cfg_pkt_elems | input | CNT_W | Elements per packet |
| cfg_burst_len | input | BL_W | Beats per full burst |
| cfg_frame_sync | input | 1 | Frame-sync mode bit |
| cfg_block_sync | input | 1 | Block-sync mode bit |
| cfg_pkt_on_dst | input | 1 | 0: source is the peripheral side, 1: destination is |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| req | input | 1 | Peripheral request pulse |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_rd_addr | output | ADDR_W | Read address of the command |
| cmd_wr_addr | output | ADDR_W | Write address of the command |
| cmd_beats | output | BL_W | Elements moved by the command |
| pkt_done | output | 1 | End-of-packet pulse |
| blk_done | output | 1 | End-of-block pulse |
| ovf_err | output | 1 | Request overflow pulse |
| cfg_err | output | 1 | Rejected configuration pulse |
| busy | output | 1 | Channel armed |

## Verification
A command appears on cmd_valid one cycle after the request edge that starts its packet, and it is accepted at the first edge where cmd_ready is high. The end-of-packet and end-of-block pulses are registered, so they are due exactly one cycle after the accepting edge, while cfg_err and ovf_err are due one cycle after the start or request edge that causes them. The scoreboard samples every output at the falling edge, pops the next expected command only on a handshake seen there, and checks the completion flags of that command at the following falling edge. Ready is driven just after each rising edge, always high, pseudo-random or held low, so stalls exercise the hold rule.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2
  } pxs_state_e;

  localparam logic [1:0] SIZE_CODE_MAX = 2'd2;

endpackage

// File: rtl/pxs_cfg_check.sv
module pxs_cfg_check #(
  parameter int CNT_W     = 16,
  parameter int BL_W      = 5,
  parameter int MAX_BURST = 16
) (
  input  logic [CNT_W-1:0] frame_elems,
  input  logic [CNT_W-1:0] block_frames,
  input  logic [1:0]       elem_size,
  input  logic [CNT_W-1:0] pkt_elems,
  input  logic [BL_W-1:0]  burst_len,
  input  logic             frame_sync,
  input  logic             block_sync,
  output logic             cfg_ok
);

  localparam logic [BL_W-1:0] BURST_CAP = BL_W'(MAX_BURST);

  logic counts_ok;
  logic burst_ok;
  logic size_ok;
  logic mode_ok;

  always_comb begin
    counts_ok = (frame_elems != '0) && (block_frames != '0) && (pkt_elems != '0);
    burst_ok  = (burst_len != '0) && (burst_len <= BURST_CAP);
    size_ok   = (elem_size <= pxs_pkg::SIZE_CODE_MAX);
    mode_ok   = frame_sync && block_sync;
    cfg_ok    = counts_ok && burst_ok && size_ok && mode_ok;
  end

endmodule

// File: rtl/pxs_chunk.sv
module pxs_chunk #(
  parameter int CNT_W = 16,
  parameter int BL_W  = 5,
  parameter int BLK_W = 32
) (
  input  logic [CNT_W-1:0] pkt_size,
  input  logic [BLK_W-1:0] block_left,
  input  logic [CNT_W-1:0] pkt_left,
  input  logic [BL_W-1:0]  burst_len,
  output logic [CNT_W-1:0] next_pkt_len,
  output logic [BL_W-1:0]  beats,
  output logic             pkt_last,
  output logic             blk_last
);

  logic [CNT_W-1:0] burst_ext;
  logic [BLK_W-1:0] pkt_size_ext;

  always_comb begin
    burst_ext    = CNT_W'(burst_len);
    pkt_size_ext = BLK_W'(pkt_size);
    // a short final packet takes only what is left of the block
    if (block_left < pkt_size_ext) begin
      next_pkt_len = block_left[CNT_W-1:0];
    end else begin
      next_pkt_len = pkt_size;
    end
    // a burst is clipped at the packet edge
    if (pkt_left < burst_ext) begin
      beats = pkt_left[BL_W-1:0];
    end else begin
      beats = burst_len;
    end
    pkt_last = (CNT_W'(beats) == pkt_left);
    blk_last = (BLK_W'(beats) == block_left);
  end

endmodule

// File: rtl/pxs_req_track.sv
module pxs_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic waiting,
  input  logic in_packet,
  input  logic req,
  output logic start_pkt,
  output logic ovf
);

  logic pend_q, pend_d;
  logic ovf_q, ovf_d;

  always_comb begin
    start_pkt = waiting && (pend_q || req);
    pend_d    = pend_q;
    ovf_d     = 1'b0;
    if (idle) begin
      pend_d = 1'b0;
    end else if (waiting) begin
      // held request is consumed first; a fresh one takes its slot
      pend_d = pend_q && req;
    end else if (in_packet && req) begin
      pend_d = 1'b1;
      ovf_d  = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf = ovf_q;

  p_ovf_needs_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(pend_q));

  p_idle_no_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) |-> !pend_q);

endmodule

// File: rtl/pkt_xfer_seq.sv
module pkt_xfer_seq #(
  parameter int CNT_W     = 16,
  parameter int MAX_BURST = 16,
  parameter int ADDR_W    = 32,
  parameter int BL_W      = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_frame_elems,
  input  logic [CNT_W-1:0]  cfg_block_frames,
  input  logic [1:0]        cfg_elem_size,
  input  logic [CNT_W-1:0]  cfg_pkt_elems,
  input  logic [BL_W-1:0]   cfg_burst_len,
  input  logic              cfg_frame_sync,
  input  logic              cfg_block_sync,
  input  logic              cfg_pkt_on_dst,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic              req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_rd_addr,
  output logic [ADDR_W-1:0] cmd_wr_addr,
  output logic [BL_W-1:0]   cmd_beats,
  output logic              pkt_done,
  output logic              blk_done,
  output logic              ovf_err,
  output logic              cfg_err,
  output logic              busy
);

  import pxs_pkg::*;

  localparam int BLK_W = 2 * CNT_W;

  pxs_state_e        state_q, state_d;
  logic [BLK_W-1:0]  blk_left_q, blk_left_d;
  logic [CNT_W-1:0]  pkt_left_q, pkt_left_d;
  logic [CNT_W-1:0]  pkt_size_q, pkt_size_d;
  logic [BL_W-1:0]   burst_q, burst_d;
  logic [1:0]        size_q, size_d;
  logic              side_q, side_d;
  logic [ADDR_W-1:0] rd_q, rd_d;
  logic [ADDR_W-1:0] wr_q, wr_d;
  logic              eop_q, eop_d;
  logic              eob_q, eob_d;
  logic              cerr_q, cerr_d;

  logic              cfg_ok;
  logic              start_pkt;
  logic [CNT_W-1:0]  next_pkt_len;
  logic [BL_W-1:0]   beats;
  logic              pkt_last;
  logic              blk_last;
  logic              accept;
  logic [ADDR_W-1:0] step;
  logic [BLK_W-1:0]  blk_total;

  pxs_cfg_check #(
    .CNT_W     (CNT_W),
    .BL_W      (BL_W),
    .MAX_BURST (MAX_BURST)
  ) u_cfg (
    .frame_elems  (cfg_frame_elems),
    .block_frames (cfg_block_frames),
    .elem_size    (cfg_elem_size),
    .pkt_elems    (cfg_pkt_elems),
    .burst_len    (cfg_burst_len),
    .frame_sync   (cfg_frame_sync),
    .block_sync   (cfg_block_sync),
    .cfg_ok       (cfg_ok)
  );

  pxs_chunk #(
    .CNT_W (CNT_W),
    .BL_W  (BL_W),
    .BLK_W (BLK_W)
  ) u_chunk (
    .pkt_size     (pkt_size_q),
    .block_left   (blk_left_q),
    .pkt_left     (pkt_left_q),
    .burst_len    (burst_q),
    .next_pkt_len (next_pkt_len),
    .beats        (beats),
    .pkt_last     (pkt_last),
    .blk_last     (blk_last)
  );

  pxs_req_track u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (state_q == ST_IDLE),
    .waiting   (state_q == ST_WAIT),
    .in_packet (state_q == ST_ISSUE),
    .req       (req),
    .start_pkt (start_pkt),
    .ovf       (ovf_err)
  );

  always_comb begin
    cmd_valid = (state_q == ST_ISSUE);
    accept    = cmd_valid && cmd_ready;
    step      = ADDR_W'(beats) << size_q;
    blk_total = BLK_W'(cfg_block_frames) * BLK_W'(cfg_frame_elems);
  end

  // next-state process
  always_comb begin
    state_d    = state_q;
    blk_left_d = blk_left_q;
    pkt_left_d = pkt_left_q;
    pkt_size_d = pkt_size_q;
    burst_d    = burst_q;
    size_d     = size_q;
    side_d     = side_q;
    rd_d       = rd_q;
    wr_d       = wr_q;
    eop_d      = 1'b0;
    eob_d      = 1'b0;
    cerr_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_ok) begin
            state_d    = ST_WAIT;
            blk_left_d = blk_total;
            pkt_left_d = '0;
            pkt_size_d = cfg_pkt_elems;
            burst_d    = cfg_burst_len;
            size_d     = cfg_elem_size;
            side_d     = cfg_pkt_on_dst;
            rd_d       = cfg_src_base;
            wr_d       = cfg_dst_base;
          end else begin
            cerr_d = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (start_pkt) begin
          state_d    = ST_ISSUE;
          pkt_left_d = next_pkt_len;
        end
      end
      ST_ISSUE: begin
        if (accept) begin
          pkt_left_d = pkt_left_q - CNT_W'(beats);
          blk_left_d = blk_left_q - BLK_W'(beats);
          if (side_q) begin
            rd_d = rd_q + step;
          end else begin
            wr_d = wr_q + step;
          end
          eop_d = pkt_last;
          eob_d = blk_last;
          if (blk_last) begin
            state_d = ST_IDLE;
          end else if (pkt_last) begin
            state_d = ST_WAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      blk_left_q <= '0;
      pkt_left_q <= '0;
      pkt_size_q <= '0;
      burst_q    <= '0;
      size_q     <= '0;
      side_q     <= 1'b0;
      rd_q       <= '0;
      wr_q       <= '0;
      eop_q      <= 1'b0;
      eob_q      <= 1'b0;
      cerr_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      blk_left_q <= blk_left_d;
      pkt_left_q <= pkt_left_d;
      pkt_size_q <= pkt_size_d;
      burst_q    <= burst_d;
      size_q     <= size_d;
      side_q     <= side_d;
      rd_q       <= rd_d;
      wr_q       <= wr_d;
      eop_q      <= eop_d;
      eob_q      <= eob_d;
      cerr_q     <= cerr_d;
    end
  end

  assign cmd_rd_addr = rd_q;
  assign cmd_wr_addr = wr_q;
  assign cmd_beats   = beats;
  assign pkt_done    = eop_q;
  assign blk_done    = eob_q;
  assign cfg_err     = cerr_q;
  assign busy        = (state_q != ST_IDLE);

  p_cfg_err_stays_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  p_block_drained_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (blk_left_q == '0));

  p_beats_in_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != '0) && (cmd_beats <= burst_q)
                  && (CNT_W'(cmd_beats) <= pkt_left_q));

  p_fixed_side_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (side_q ? $stable(wr_q) : $stable(rd_q)));

  p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_beats)
                                  && $stable(cmd_rd_addr) && $stable(cmd_wr_addr));

  p_eob_with_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> pkt_done);

  p_eop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  p_idle_after_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> !busy);

endmodule

// File: tb/sim_pkt_xfer_seq.sv
module sim_pkt_xfer_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int MAX_BURST  = 16;
  localparam int ADDR_W     = 32;
  localparam int BL_W       = $clog2(MAX_BURST + 1);

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [CNT_W-1:0]  cfg_frame_elems;
  logic [CNT_W-1:0]  cfg_block_frames;
  logic [1:0]        cfg_elem_size;
  logic [CNT_W-1:0]  cfg_pkt_elems;
  logic [BL_W-1:0]   cfg_burst_len;
  logic              cfg_frame_sync;
  logic              cfg_block_sync;
  logic              cfg_pkt_on_dst;
  logic [ADDR_W-1:0] cfg_src_base;
  logic [ADDR_W-1:0] cfg_dst_base;
  logic              req;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_rd_addr;
  logic [ADDR_W-1:0] cmd_wr_addr;
  logic [BL_W-1:0]   cmd_beats;
  logic              pkt_done;
  logic              blk_done;
  logic              ovf_err;
  logic              cfg_err;
  logic              busy;

  pkt_xfer_seq #(
    .CNT_W     (CNT_W),
    .MAX_BURST (MAX_BURST),
    .ADDR_W    (ADDR_W)
  ) u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .start            (start),
    .cfg_frame_elems  (cfg_frame_elems),
    .cfg_block_frames (cfg_block_frames),
    .cfg_elem_size    (cfg_elem_size),
    .cfg_pkt_elems    (cfg_pkt_elems),
    .cfg_burst_len    (cfg_burst_len),
    .cfg_frame_sync   (cfg_frame_sync),
    .cfg_block_sync   (cfg_block_sync),
    .cfg_pkt_on_dst   (cfg_pkt_on_dst),
    .cfg_src_base     (cfg_src_base),
    .cfg_dst_base     (cfg_dst_base),
    .req              (req),
    .cmd_valid        (cmd_valid),
    .cmd_ready        (cmd_ready),
    .cmd_rd_addr      (cmd_rd_addr),
    .cmd_wr_addr      (cmd_wr_addr),
    .cmd_beats        (cmd_beats),
    .pkt_done         (pkt_done),
    .blk_done         (blk_done),
    .ovf_err          (ovf_err),
    .cfg_err          (cfg_err),
    .busy             (busy)
  );

  typedef struct {
    int          beats;
    logic [31:0] rd;
    logic [31:0] wr;
    bit          eop;
    bit          eob;
  } exp_cmd_t;

  exp_cmd_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  int eop_seen = 0;
  int eob_seen = 0;
  int ovf_seen = 0;
  int cerr_seen = 0;
  int beats_sum = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // ready driver: updated just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: cmd_ready = 1'b1;
      1: cmd_ready = lfsr[0];
      default: cmd_ready = 1'b0;
    endcase
  end

  // monitor: samples at the falling edge
  bit          flags_due = 0;
  bit          exp_eop_r = 0;
  bit          exp_eob_r = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_rd, prev_wr;
  int          prev_beats;

  always @(negedge clk) begin
    if (rst_n) begin
      if (flags_due) begin
        check("R8 pkt_done", pkt_done, exp_eop_r);
        check("R8 blk_done", blk_done, exp_eob_r);
        flags_due = 0;
      end else if (pkt_done || blk_done) begin
        check("R8 stray done pulse", {pkt_done, blk_done}, 0);
      end
      if (pkt_done) eop_seen++;
      if (blk_done) eob_seen++;
      if (ovf_err) ovf_seen++;
      if (cfg_err) cerr_seen++;
      if (prev_stall) begin
        check("R7 valid held", cmd_valid, 1);
        check("R7 beats held", cmd_beats, prev_beats);
        check("R7 rd held", cmd_rd_addr, prev_rd);
        check("R7 wr held", cmd_wr_addr, prev_wr);
      end
      if (cmd_valid) begin
        if (exp_q.size() == 0) begin
          check("R10/R11 unexpected command", cmd_valid, 0);
        end else if (cmd_ready) begin
          exp_cmd_t e;
          e = exp_q.pop_front();
          check("R4 beats", cmd_beats, e.beats);
          check("R6 rd addr", cmd_rd_addr, e.rd);
          check("R6 wr addr", cmd_wr_addr, e.wr);
          beats_sum += int'(cmd_beats);
          exp_eop_r = e.eop;
          exp_eob_r = e.eob;
          flags_due = 1;
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_beats = int'(cmd_beats);
      prev_rd    = cmd_rd_addr;
      prev_wr    = cmd_wr_addr;
    end
  end

  // driver side: expected command list from the requirements
  task automatic build_expect(input int fe, input int bf, input int sz, input int pk,
                              input int bl, input logic [31:0] src, input logic [31:0] dst,
                              input bit on_dst);
    int total;
    logic [31:0] rd, wr;
    total = fe * bf;
    rd = src;
    wr = dst;
    while (total > 0) begin
      int p;
      p = (pk < total) ? pk : total;
      while (p > 0) begin
        exp_cmd_t e;
        int b;
        b = (bl < p) ? bl : p;
        e.beats = b;
        e.rd = rd;
        e.wr = wr;
        e.eop = (p == b);
        e.eob = (total == b);
        exp_q.push_back(e);
        if (on_dst) rd = rd + (b << sz);
        else        wr = wr + (b << sz);
        p -= b;
        total -= b;
      end
    end
  endtask

  task automatic set_cfg(input int fe, input int bf, input int sz, input int pk,
                         input int bl, input bit fs, input bit bs, input bit on_dst,
                         input logic [31:0] src, input logic [31:0] dst);
    cfg_frame_elems  = CNT_W'(fe);
    cfg_block_frames = CNT_W'(bf);
    cfg_elem_size    = 2'(sz);
    cfg_pkt_elems    = CNT_W'(pk);
    cfg_burst_len    = BL_W'(bl);
    cfg_frame_sync   = fs;
    cfg_block_sync   = bs;
    cfg_pkt_on_dst   = on_dst;
    cfg_src_base     = src;
    cfg_dst_base     = dst;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic pulse_req();
    @(posedge clk); #1 req = 1'b1;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic wait_eop(input int n);
    while (eop_seen < n) @(posedge clk);
  endtask

  // run one whole block, one request per packet
  task automatic run_block(input string tag, input int fe, input int bf, input int sz,
                           input int pk, input int bl, input bit on_dst,
                           input logic [31:0] src, input logic [31:0] dst);
    int npk, e0, b0;
    npk = (fe * bf + pk - 1) / pk;
    set_cfg(fe, bf, sz, pk, bl, 1, 1, on_dst, src, dst);
    build_expect(fe, bf, sz, pk, bl, src, dst, on_dst);
    e0 = eop_seen;
    b0 = eob_seen;
    beats_sum = 0;
    pulse_start();
    repeat (3) @(posedge clk);
    for (int i = 0; i < npk; i++) begin
      pulse_req();
      wait_eop(e0 + i + 1);
      repeat (2) @(posedge clk);
    end
    check({tag, " R3 packets"}, eop_seen - e0, npk);
    check({tag, " R2 total beats"}, beats_sum, fe * bf);
    check({tag, " R2 blk_done"}, eob_seen - b0, 1);
    check({tag, " R5 queue drained"}, exp_q.size(), 0);
    check({tag, " R10 idle"}, busy, 0);
  endtask

  task automatic bad_start(input string tag);
    int c0;
    c0 = cerr_seen;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    check({tag, " R1 cfg_err"}, cfg_err, 1);
    check({tag, " R1 busy"}, busy, 0);
    repeat (2) @(posedge clk);
    #1;
    check({tag, " R1 single pulse"}, cerr_seen - c0, 1);
    check({tag, " R1 no command"}, cmd_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    req   = 1'b0;
    cmd_ready = 1'b1;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("reset busy", busy, 0);
    check("reset cmd_valid", cmd_valid, 0);
    check("reset pulses", {pkt_done, blk_done, ovf_err, cfg_err}, 0);

    // R11: armed but no request yet
    set_cfg(8, 3, 2, 8, 4, 1, 1, 0, 32'h0000_4000, 32'h0010_0000);
    build_expect(8, 3, 2, 8, 4, 32'h0000_4000, 32'h0010_0000, 0);
    pulse_start();
    repeat (6) @(posedge clk);
    #1;
    check("R11 busy armed", busy, 1);
    check("R11 no command", cmd_valid, 0);
    beats_sum = 0;
    for (int i = 0; i < 3; i++) begin
      pulse_req();
      wait_eop(i + 1);
      repeat (2) @(posedge clk);
    end
    check("R2 aligned total", beats_sum, 24);
    check("R2 aligned blk_done", eob_seen, 1);

    // R10: requests after the block do nothing
    pulse_req();
    pulse_req();
    repeat (8) @(posedge clk);
    #1;
    check("R10 idle after requests", busy, 0);
    check("R10 no packet", eop_seen, 3);

    // R5 non-dividing packet, R4 split, R6 destination side fixed, stalls
    rdy_mode = 1;
    run_block("T2", 10, 2, 1, 6, 4, 1, 32'h0002_0000, 32'h0000_8000);
    // burst longer than packet, byte elements
    run_block("T3", 5, 1, 0, 3, 8, 0, 32'h0000_0100, 32'h0000_0200);
    // single-beat bursts
    rdy_mode = 0;
    run_block("T4", 3, 2, 2, 4, 1, 0, 32'h0000_1000, 32'h0000_3000);

    // R9: pending request and overflow
    begin
      int e0, o0;
      rdy_mode = 2;
      set_cfg(4, 3, 2, 4, 4, 1, 1, 0, 32'h0000_0040, 32'h0000_0800);
      build_expect(4, 3, 2, 4, 4, 32'h0000_0040, 32'h0000_0800, 0);
      e0 = eop_seen;
      o0 = ovf_seen;
      pulse_start();
      pulse_req();
      repeat (2) @(posedge clk);
      pulse_req();
      repeat (2) @(posedge clk);
      #1;
      check("R9 no overflow with one held", ovf_seen - o0, 0);
      pulse_req();
      repeat (2) @(posedge clk);
      #1;
      check("R9 overflow pulse", ovf_seen - o0, 1);
      rdy_mode = 0;
      wait_eop(e0 + 2);
      repeat (4) @(posedge clk);
      #1;
      check("R9 held request served", eop_seen - e0, 2);
      check("R9 waits for next request", busy, 1);
      pulse_req();
      wait_eop(e0 + 3);
      repeat (2) @(posedge clk);
      #1;
      check("R9 block finished", busy, 0);
      check("R9 queue drained", exp_q.size(), 0);
    end

    // R1 rejected configurations
    set_cfg(4, 2, 3, 4, 4, 1, 1, 0, 0, 0);
    bad_start("size3");
    set_cfg(4, 2, 0, 4, 4, 0, 1, 0, 0, 0);
    bad_start("fs0");
    set_cfg(4, 2, 0, 0, 4, 1, 1, 0, 0, 0);
    bad_start("pkt0");
    set_cfg(0, 2, 0, 4, 4, 1, 1, 0, 0, 0);
    bad_start("elems0");
    set_cfg(4, 2, 0, 4, 17, 1, 1, 0, 0, 0);
    bad_start("burst17");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule